// File: doc/BRIEF.md
# Page Access Permission and Fault Checker

This block sits behind a translation lookup and turns the looked-up page descriptor into a final verdict for one memory access. It takes the descriptor fields as inputs: hit and valid flags, physical base, range start, access id, two privilege bounds, rights type, and the break, dirty and reference flags. It also takes the requested virtual address, the current privilege level, the access kind, a protection-id enable with four protection-id registers, and a translation-disable flag. From these it produces the physical address, the granted read/write/execute set, and a single fault code.

A request is presented with a one-cycle `in_valid` strobe. The verdict appears registered on the next clock edge with `out_valid` set, and it is held until the next strobe. Any fault has already been prioritised, so the core only needs to act on one code. When translation is disabled, the address passes through unchanged with full rights. Otherwise the descriptor rights are reduced in stages: protection-id matching, the requested-permission test, and then the dirty, break and reference checks. The reference check takes final priority.

Top module: `pagechk_top`

## Requirements
- R1: With `xlat_off`=1, the result is `out_pa`=`req_va`, `out_perm`=3'b111 and `out_fault`=0 (none), whatever the descriptor holds.
- R2: With translation on and `lk_hit`=0 or `lk_valid`=0, the result is `out_perm`=0 and `out_pa`=0. The fault is 1 (instruction miss) when `acc_type`=3 (execute) and 2 (data miss) for any other access kind.
- R3: On a usable entry, `out_pa` = `lk_pbase` + (`req_va` - `lk_vstart`), modulo 2^ADDR_W.
- R4: Permission bits are `out_perm[0]` read, `[1]` write and `[2]` execute. Read is eligible when `cur_priv` <= `lk_pl1`, and write when `cur_priv` <= `lk_pl2`. Execute is eligible when `lk_pl2` <= `cur_priv` <= `lk_pl1`.
- R5: `lk_rtype` picks the eligible bits as follows: 0 gives read only; 1 gives read and write; 2 gives read and execute; 3 gives all three; 4 through 7 give execute only.
- R6: When `pid_chk_en`=1 and `lk_aid`!=0, the value {`lk_aid`,1'b1} is compared with each slice of `pid_regs`. A match clears write. A write access (`acc_type`=2) that matches gets fault 3 and no further checks.
- R7: `acc_type`=0 (none) never gets a fault other than a miss (R2). It returns the rights left after R4 to R6.
- R8: If the requested bit is missing after R6, the fault is 4 for execute and 5 for read or write, and no further checks run. Read is `acc_type`=1.
- R9: Next, in order: `lk_dirty`=0 clears write and faults a write with 6. Then `lk_brk`=1 clears write and faults a write with 7. Then `lk_ref`=1 keeps only execute and faults any non-execute access with 8. A later fault replaces an earlier one.
- R10: Each `in_valid` strobe yields `out_valid` on the next cycle. Without a strobe, `out_valid` is 0 and `out_pa`, `out_perm` and `out_fault` keep their last values.
- R11: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| xlat_off | input | 1 | Translation disabled, direct mapping |
| lk_hit | input | 1 | Lookup found an entry |
| lk_valid | input | 1 | Found entry is valid |
| lk_pbase | input | ADDR_W | Physical base of the entry |
| lk_vstart | input | ADDR_W | Virtual start of the entry range |
| lk_aid | input | AID_W | Access id, 0 means public |
| lk_pl1 | input | PL_W | Upper privilege bound |
| lk_pl2 | input | PL_W | Write/lower privilege bound |
| lk_rtype | input | 3 | Rights type |
| lk_brk | input | 1 | Break flag |
| lk_dirty | input | 1 | Dirty flag |
| lk_ref | input | 1 | Reference trap flag |
| req_va | input | ADDR_W | Requested virtual address |
| cur_priv | input | PL_W | Current privilege level |
| pid_chk_en | input | 1 | Protection-id check enable |
| pid_regs | input | NUM_PID*(AID_W+1) | Protection-id registers, slot i at bits [i*(AID_W+1) +: AID_W+1] |
| acc_type | input | 2 | 0 none, 1 read, 2 write, 3 execute |
| out_valid | output | 1 | Result strobe |
| out_pa | output | ADDR_W | Physical address |
| out_perm | output | 3 | Granted rights {exec, write, read} |
| out_fault | output | 4 | Fault code, 0 = none |

## Verification
Directed cases go through every rights type with the privilege below, between and above the two bounds, so each comparison of R4 can be told apart from its neighbours. Fault-ordering patterns set several of dirty, break and reference together under read, write and execute accesses. These show the reference fault replacing the others and that only writes reach dirty and break. Protection-id patterns vary the matching slot, a zero access id and the enable, which separates the suppression from the R8 rights fault. A random phase mixes miss, bypass and kind-none requests with back-to-back and idle cycles. This checks the one-cycle latency and that results are held between strobes.

// File: rtl/pagechk_pkg.sv
package pagechk_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_EXEC  = 2'd3
    } acc_e;

    typedef enum logic [3:0] {
        FLT_NONE      = 4'd0,
        FLT_IMISS     = 4'd1,
        FLT_DMISS     = 4'd2,
        FLT_PID_WRITE = 4'd3,
        FLT_IPROT     = 4'd4,
        FLT_DRIGHTS   = 4'd5,
        FLT_DIRTY     = 4'd6,
        FLT_BREAK     = 4'd7,
        FLT_PAGEREF   = 4'd8
    } fault_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;

endpackage

// File: rtl/pagechk_rights.sv
module pagechk_rights #(
    parameter int PL_W = 2
) (
    input  logic [PL_W-1:0] priv,
    input  logic [PL_W-1:0] pl1,
    input  logic [PL_W-1:0] pl2,
    input  logic [2:0]      rtype,
    output logic [2:0]      perm
);
    import pagechk_pkg::*;

    logic rd_ok, wr_ok, ex_ok;

    always_comb begin
        rd_ok = (priv <= pl1);
        wr_ok = (priv <= pl2);
        ex_ok = (pl2 <= priv) && (priv <= pl1);
        perm  = '0;
        unique case (rtype)
            3'd0: perm[PERM_R] = rd_ok;
            3'd1: begin
                perm[PERM_R] = rd_ok;
                perm[PERM_W] = wr_ok;
            end
            3'd2: begin
                perm[PERM_R] = rd_ok;
                perm[PERM_X] = ex_ok;
            end
            3'd3: begin
                perm[PERM_R] = rd_ok;
                perm[PERM_W] = wr_ok;
                perm[PERM_X] = ex_ok;
            end
            default: perm[PERM_X] = ex_ok;
        endcase
    end

endmodule

// File: rtl/pagechk_pid_match.sv
module pagechk_pid_match #(
    parameter int AID_W   = 18,
    parameter int NUM_PID = 4,
    localparam int PID_W  = AID_W + 1
) (
    input  logic [AID_W-1:0]         aid,
    input  logic                     chk_en,
    input  logic [NUM_PID*PID_W-1:0] pid_regs,
    output logic                     match
);
    logic [PID_W-1:0]   key;
    logic [NUM_PID-1:0] slot_hit;

    assign key = {aid, 1'b1};

    for (genvar g = 0; g < NUM_PID; g++) begin : g_slot
        assign slot_hit[g] = (pid_regs[g*PID_W +: PID_W] == key);
    end

    assign match = chk_en && (aid != '0) && (|slot_hit);

endmodule

// File: rtl/pagechk_fault_chain.sv
module pagechk_fault_chain (
    input  pagechk_pkg::acc_e   acc,
    input  logic [2:0]          base_perm,
    input  logic                pid_hit,
    input  logic                dirty,
    input  logic                brk,
    input  logic                ref_trap,
    output logic [2:0]          perm,
    output pagechk_pkg::fault_e fault
);
    import pagechk_pkg::*;

    logic       done;
    logic [2:0] need;

    always_comb begin
        perm  = base_perm;
        fault = FLT_NONE;
        done  = 1'b0;
        need  = '0;

        // stage 1: protection-id suppression
        if (pid_hit) begin
            perm[PERM_W] = 1'b0;
            if (acc == ACC_WRITE) begin
                fault = FLT_PID_WRITE;
                done  = 1'b1;
            end
        end

        // stage 2: a non-access takes the translation as is
        if (!done && acc == ACC_NONE) begin
            done = 1'b1;
        end

        // stage 3: requested right must be present
        if (!done) begin
            unique case (acc)
                ACC_READ:  need = 3'b001;
                ACC_WRITE: need = 3'b010;
                default:   need = 3'b100;
            endcase
            if ((perm & need) == '0) begin
                fault = (acc == ACC_EXEC) ? FLT_IPROT : FLT_DRIGHTS;
                done  = 1'b1;
            end
        end

        // stage 4: dirty, break, reference; later overrides earlier
        if (!done) begin
            if (!dirty) begin
                if (acc == ACC_WRITE) fault = FLT_DIRTY;
                perm[PERM_W] = 1'b0;
            end
            if (brk) begin
                if (acc == ACC_WRITE) fault = FLT_BREAK;
                perm[PERM_W] = 1'b0;
            end
            if (ref_trap) begin
                if (acc != ACC_EXEC) fault = FLT_PAGEREF;
                perm[PERM_R] = 1'b0;
                perm[PERM_W] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pagechk_top.sv
module pagechk_top #(
    parameter int ADDR_W  = 32,
    parameter int AID_W   = 18,
    parameter int PL_W    = 2,
    parameter int NUM_PID = 4,
    localparam int PID_W  = AID_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     xlat_off,
    input  logic                     lk_hit,
    input  logic                     lk_valid,
    input  logic [ADDR_W-1:0]        lk_pbase,
    input  logic [ADDR_W-1:0]        lk_vstart,
    input  logic [AID_W-1:0]         lk_aid,
    input  logic [PL_W-1:0]          lk_pl1,
    input  logic [PL_W-1:0]          lk_pl2,
    input  logic [2:0]               lk_rtype,
    input  logic                     lk_brk,
    input  logic                     lk_dirty,
    input  logic                     lk_ref,
    input  logic [ADDR_W-1:0]        req_va,
    input  logic [PL_W-1:0]          cur_priv,
    input  logic                     pid_chk_en,
    input  logic [NUM_PID*PID_W-1:0] pid_regs,
    input  logic [1:0]               acc_type,
    output logic                     out_valid,
    output logic [ADDR_W-1:0]        out_pa,
    output logic [2:0]               out_perm,
    output logic [3:0]               out_fault
);
    import pagechk_pkg::*;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] pa;
        logic [2:0]        perm;
        fault_e            fault;
    } res_t;

    res_t       res_d, res_q;
    acc_e       acc;
    logic [2:0] base_perm;
    logic       pid_hit;
    logic [2:0] chain_perm;
    fault_e     chain_fault;

    assign acc = acc_e'(acc_type);

    pagechk_rights #(.PL_W(PL_W)) u_rights (
        .priv  (cur_priv),
        .pl1   (lk_pl1),
        .pl2   (lk_pl2),
        .rtype (lk_rtype),
        .perm  (base_perm)
    );

    pagechk_pid_match #(.AID_W(AID_W), .NUM_PID(NUM_PID)) u_pid (
        .aid      (lk_aid),
        .chk_en   (pid_chk_en),
        .pid_regs (pid_regs),
        .match    (pid_hit)
    );

    pagechk_fault_chain u_chain (
        .acc       (acc),
        .base_perm (base_perm),
        .pid_hit   (pid_hit),
        .dirty     (lk_dirty),
        .brk       (lk_brk),
        .ref_trap  (lk_ref),
        .perm      (chain_perm),
        .fault     (chain_fault)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            if (xlat_off) begin
                res_d.pa    = req_va;
                res_d.perm  = 3'b111;
                res_d.fault = FLT_NONE;
            end else if (!lk_hit || !lk_valid) begin
                res_d.pa    = '0;
                res_d.perm  = '0;
                res_d.fault = (acc == ACC_EXEC) ? FLT_IMISS : FLT_DMISS;
            end else begin
                res_d.pa    = lk_pbase + (req_va - lk_vstart);
                res_d.perm  = chain_perm;
                res_d.fault = chain_fault;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '{vld: 1'b0, pa: '0, perm: '0, fault: FLT_NONE};
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign out_pa    = res_q.pa;
    assign out_perm  = res_q.perm;
    assign out_fault = res_q.fault;

endmodule

// File: rtl/pagechk_sva.sv
module pagechk_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              xlat_off,
    input logic [1:0]        acc_type,
    input logic [ADDR_W-1:0] req_va,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_pa,
    input logic [2:0]        out_perm,
    input logic [3:0]        out_fault
);
    AST_BYPASS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(xlat_off)) |->
        (out_perm == 3'b111 && out_fault == 4'd0 && out_pa == $past(req_va))); // R1

    AST_MISS_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_fault == 4'd1 || out_fault == 4'd2)) |->
        (out_perm == 3'b000 && out_pa == '0)); // R2

    AST_NONE_NO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(acc_type) == 2'd0) |->
        (out_fault == 4'd0 || out_fault == 4'd2)); // R7

    AST_PID_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault == 4'd3) |->
        ($past(acc_type) == 2'd2 && out_perm[1] == 1'b0)); // R6

    AST_REF_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault == 4'd8) |-> (out_perm[1:0] == 2'b00)); // R9

    AST_WRITE_FLT_NO_W: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_fault == 4'd6 || out_fault == 4'd7)) |->
        ($past(acc_type) == 2'd2 && out_perm[1] == 1'b0)); // R9

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_pa) && $stable(out_perm) && $stable(out_fault))); // R10

endmodule

bind pagechk_top pagechk_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .xlat_off  (xlat_off),
    .acc_type  (acc_type),
    .req_va    (req_va),
    .out_valid (out_valid),
    .out_pa    (out_pa),
    .out_perm  (out_perm),
    .out_fault (out_fault)
);

// File: tb/pagechk_top_tb.sv
module pagechk_top_tb;
    localparam int AW = 32;
    localparam int AIDW = 18;
    localparam int PW = 19;

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0, xlat_off = 0, lk_hit = 0, lk_valid = 0;
    logic [AW-1:0] lk_pbase = 0, lk_vstart = 0, req_va = 0;
    logic [AIDW-1:0] lk_aid = 0;
    logic [1:0] lk_pl1 = 0, lk_pl2 = 0, cur_priv = 0, acc_type = 0;
    logic [2:0] lk_rtype = 0;
    logic lk_brk = 0, lk_dirty = 0, lk_ref = 0, pid_chk_en = 0;
    logic [4*PW-1:0] pid_regs = 0;
    logic out_valid;
    logic [AW-1:0] out_pa;
    logic [2:0] out_perm;
    logic [3:0] out_fault;

    always #5 clk = ~clk;

    pagechk_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .xlat_off(xlat_off),
        .lk_hit(lk_hit), .lk_valid(lk_valid), .lk_pbase(lk_pbase),
        .lk_vstart(lk_vstart), .lk_aid(lk_aid), .lk_pl1(lk_pl1),
        .lk_pl2(lk_pl2), .lk_rtype(lk_rtype), .lk_brk(lk_brk),
        .lk_dirty(lk_dirty), .lk_ref(lk_ref), .req_va(req_va),
        .cur_priv(cur_priv), .pid_chk_en(pid_chk_en), .pid_regs(pid_regs),
        .acc_type(acc_type), .out_valid(out_valid), .out_pa(out_pa),
        .out_perm(out_perm), .out_fault(out_fault)
    );

    typedef struct {
        logic [AW-1:0] pa;
        logic [2:0]    perm;
        logic [3:0]    fault;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t last;
    bit   have_last = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model built from the requirement list
    function automatic exp_t model();
        exp_t e;
        logic r, w, x, pid;
        logic [PW-1:0] key;
        e.tag = "";
        e.fault = 4'd0;
        if (xlat_off) begin                         // R1
            e.pa = req_va; e.perm = 3'b111; return e;
        end
        if (!lk_hit || !lk_valid) begin             // R2
            e.pa = 0; e.perm = 0;
            e.fault = (acc_type == 2'd3) ? 4'd1 : 4'd2;
            return e;
        end
        e.pa = lk_pbase + (req_va - lk_vstart);     // R3
        r = cur_priv <= lk_pl1;                     // R4
        w = cur_priv <= lk_pl2;
        x = (lk_pl2 <= cur_priv) && (cur_priv <= lk_pl1);
        case (lk_rtype)                             // R5
            3'd0: e.perm = {1'b0, 1'b0, r};
            3'd1: e.perm = {1'b0, w, r};
            3'd2: e.perm = {x, 1'b0, r};
            3'd3: e.perm = {x, w, r};
            default: e.perm = {x, 1'b0, 1'b0};
        endcase
        key = {lk_aid, 1'b1};                       // R6
        pid = 0;
        for (int i = 0; i < 4; i++) if (pid_regs[i*PW +: PW] == key) pid = 1;
        if (pid && pid_chk_en && lk_aid != 0) begin
            e.perm[1] = 0;
            if (acc_type == 2'd2) begin e.fault = 4'd3; return e; end
        end
        if (acc_type == 2'd0) return e;             // R7
        if ((acc_type == 2'd1 && !e.perm[0]) || (acc_type == 2'd2 && !e.perm[1]) ||
            (acc_type == 2'd3 && !e.perm[2])) begin // R8
            e.fault = (acc_type == 2'd3) ? 4'd4 : 4'd5;
            return e;
        end
        if (!lk_dirty) begin                        // R9
            if (acc_type == 2'd2) e.fault = 4'd6;
            e.perm[1] = 0;
        end
        if (lk_brk) begin
            if (acc_type == 2'd2) e.fault = 4'd7;
            e.perm[1] = 0;
        end
        if (lk_ref) begin
            if (acc_type != 2'd3) e.fault = 4'd8;
            e.perm[1:0] = 2'b00;
        end
        return e;
    endfunction

    task automatic send(input string tag);
        exp_t e;
        in_valid = 1;
        e = model();
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic entry(input logic [1:0] p1, input logic [1:0] p2, input logic [2:0] rt,
                         input logic b, input logic d, input logic t);
        xlat_off = 0; lk_hit = 1; lk_valid = 1;
        lk_pl1 = p1; lk_pl2 = p2; lk_rtype = rt;
        lk_brk = b; lk_dirty = d; lk_ref = t;
    endtask

    // monitor: compares at the falling edge, away from the register update
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check("R10 unexpected out_valid", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({e.tag, " pa"}, out_pa, e.pa);
                    check({e.tag, " perm"}, out_perm, e.perm);
                    check({e.tag, " fault"}, out_fault, e.fault);
                    last = e;
                    have_last = 1;
                end
            end else if (have_last) begin
                check("R10 hold", {out_pa, out_perm, out_fault}, {last.pa, last.perm, last.fault});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset outputs", {out_valid, out_pa, out_perm, out_fault}, 0);
        rst_n = 1;
        @(negedge clk);
        check("R11 after reset", {out_valid, out_pa, out_perm, out_fault}, 0);

        lk_pbase = 32'h0004_0000; lk_vstart = 32'h1000_0000; req_va = 32'h1000_0abc;
        lk_aid = 0; pid_chk_en = 0;

        xlat_off = 1; lk_hit = 0; acc_type = 2'd2; send("R1 bypass write");
        xlat_off = 0; acc_type = 2'd3; send("R2 miss exec");
        lk_hit = 1; lk_valid = 0; acc_type = 2'd1; send("R2 invalid read");
        idle(2);

        // R3 R4 R5: all types, privilege around bounds pl2=1, pl1=2
        for (int rt = 0; rt < 8; rt++)
            for (int pv = 0; pv < 4; pv++) begin
                entry(2'd2, 2'd1, rt[2:0], 0, 1, 0);
                cur_priv = pv[1:0];
                acc_type = 2'd0; send("R5 R4 rights none");
                acc_type = 2'd3; send("R4 exec window");
            end
        req_va = 32'h1000_ffff; lk_pbase = 32'hffff_f000; entry(3, 3, 3, 0, 1, 0);
        cur_priv = 0; acc_type = 2'd1; send("R3 wrap add");

        // R6 protection id
        lk_aid = 18'h2a5a5; pid_regs = 0;
        pid_regs[2*PW +: PW] = {18'h2a5a5, 1'b1};
        pid_chk_en = 1; acc_type = 2'd2; send("R6 pid write");
        acc_type = 2'd1; send("R6 pid read");
        pid_chk_en = 0; acc_type = 2'd2; send("R6 pid disabled");
        pid_chk_en = 1; pid_regs[2*PW +: PW] = {18'h2a5a5, 1'b0}; send("R6 low bit clear");
        lk_aid = 0; pid_regs = {4{19'h1}}; send("R6 public aid");
        pid_regs = 0;

        // R7 none with all traps
        entry(3, 3, 3, 1, 0, 1); acc_type = 2'd0; send("R7 none traps");
        // R8
        entry(3, 3, 0, 0, 1, 0); acc_type = 2'd2; send("R8 write on ro");
        entry(3, 3, 1, 0, 1, 0); acc_type = 2'd3; send("R8 exec on rw");
        // R9 ordering
        entry(3, 3, 3, 0, 0, 0); acc_type = 2'd2; send("R9 dirty write");
        entry(3, 3, 3, 1, 0, 0); acc_type = 2'd2; send("R9 break over dirty");
        entry(3, 3, 3, 1, 0, 1); acc_type = 2'd2; send("R9 ref over all");
        entry(3, 3, 3, 1, 0, 1); acc_type = 2'd3; send("R9 exec with ref");
        entry(3, 3, 3, 0, 0, 0); acc_type = 2'd1; send("R9 read no dirty");
        entry(3, 3, 3, 0, 1, 1); acc_type = 2'd1; send("R9 ref read");
        idle(3);

        // random mix, R10 with gaps
        for (int i = 0; i < 400; i++) begin
            xlat_off = ($urandom_range(0, 9) == 0);
            lk_hit = ($urandom_range(0, 7) != 0);
            lk_valid = ($urandom_range(0, 7) != 0);
            lk_pbase = $urandom; lk_vstart = $urandom; req_va = $urandom;
            lk_aid = ($urandom_range(0, 3) == 0) ? 0 : 18'($urandom);
            lk_pl1 = 2'($urandom); lk_pl2 = 2'($urandom); lk_rtype = 3'($urandom);
            lk_brk = 1'($urandom); lk_dirty = 1'($urandom); lk_ref = ($urandom_range(0, 3) == 0);
            cur_priv = 2'($urandom); pid_chk_en = 1'($urandom); acc_type = 2'($urandom);
            pid_regs = {$urandom, $urandom, $urandom};
            if ($urandom_range(0, 1)) pid_regs[$urandom_range(0, 3)*PW +: PW] = {lk_aid, 1'b1};
            send("R10 random");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(4);
        check("R10 queue drained", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule